// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central bookkeeping of a small floating-point core that issues in order and lets operand reads run out of order. Five execution resources are tracked: an integer/load unit, two multipliers, an adder and a divider. Each cycle the decode stage shows the block one instruction: its operation class, its destination register and two source registers. The block answers combinationally whether that instruction may issue and which unit takes it.

Once an instruction is placed in a unit, the block decides when the unit may read its operands from the register file and when it may write its result back. A unit reports the end of its computation with a one-cycle done pulse. Operands are never forwarded. A consumer becomes ready only after its producer has written back, and the read grant follows one cycle later.

Each unit runs its own four-state machine:
- `ST_IDLE` moves to `ST_WAIT_OPS` on allocation.
- `ST_WAIT_OPS` moves to `ST_EXEC` when both sources are ready, which is the cycle the read grant is given.
- `ST_EXEC` moves to `ST_WAIT_WB` on the done pulse.
- `ST_WAIT_WB` moves to `ST_IDLE` on the write-back grant.

A 32-entry table records which unit will write each register.

Top module: `scoreboard_ctrl`

## Requirements
- R1: `iss_ready` is 1 only when the following all hold. A unit of the requested class is in `ST_IDLE`, and the result table shows no pending writer for `iss_dst`. When both hold, `iss_unit` names that unit; otherwise `iss_unit` is 0. An instruction is allocated when `iss_valid` and `iss_ready` are both 1.
- R2: Unit encoding is one-hot. The bit assignments are: bit 0 integer/load, bit 1 first multiplier, bit 2 second multiplier, bit 3 adder, bit 4 divider. The `iss_class` codes are: 0 integer/load, 1 multiply, 2 add, 3 divide. A multiply goes to the lowest-numbered free multiplier.
- R3: `rd_grant[u]` is 1 in a cycle when unit u is waiting for operands and both its sources are ready. A source is ready at allocation when no unit is recorded as its writer, or when that writer is granted write-back in the same cycle.
- R4: After a read grant, the unit executes until its `exec_done` bit pulses. A done pulse to a unit that is not executing has no effect.
- R5: A unit that has finished is held from write-back while another unit is waiting for operands and has a ready, unread source equal to the finisher's destination. Such a hold prevents a WAR hazard.
- R6: At most one unit is granted write-back per cycle. Among the eligible units, the lowest bit index wins, and the others wait.
- R7: On write-back, three things happen. The unit returns to idle. The destination's entry in the result table is cleared, so a new instruction writing that register can issue from the next cycle. Every consumer waiting on that unit becomes ready, and it may be read-granted from the next cycle.
- R8: Reset (`rst_n` low) puts every unit in `ST_IDLE` and clears the result table. Afterwards no read or write-back grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Decode offers an instruction |
| iss_class | input | 2 | Operation class (R2 codes) |
| iss_dst | input | 5 | Destination register index |
| iss_src1 | input | 5 | First source register index |
| iss_src2 | input | 5 | Second source register index |
| exec_done | input | 5 | Per-unit completion pulse |
| iss_ready | output | 1 | Offered instruction may issue |
| iss_unit | output | 5 | One-hot unit that takes the instruction, 0 if none |
| rd_grant | output | 5 | Per-unit permission to read operands this cycle |
| wb_grant | output | 5 | Per-unit permission to write back this cycle (one-hot or zero) |

## Verification
A dependent load/multiply/add/divide chain shows RAW waiting. In that chain, a consumer's read grant lands exactly one cycle after its producer's write-back, which separates correct no-forwarding behaviour from early reads.

Several other patterns each isolate one rule:
- An issue to a busy adder separates structural stalls from WAW stalls.
- An issue to a pending destination does the same, from the other side.
- A multiplier waiting on the divider, while reading a register the integer unit produces, holds the integer write-back until the read. This isolates the WAR rule from the plain busy check.
- Two units finishing together, with a second multiplier in use, exercise the lowest-index write-back order and the free-multiplier choice.

Directed cases cover stray done pulses, a reset in mid-flight and a re-issue to a destination just as it is written.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NUM_FU   = 5;
    localparam int NUM_REGS = 32;
    localparam int REG_W    = $clog2(NUM_REGS);

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_MUL = 2'd1,
        CL_ADD = 2'd2,
        CL_DIV = 2'd3
    } fu_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_OPS,
        ST_EXEC,
        ST_WAIT_WB
    } fu_state_e;

    // unit index -> operation class it serves
    function automatic fu_class_e unit_class(input int idx);
        case (idx)
            0:       return CL_INT;
            1, 2:    return CL_MUL;
            3:       return CL_ADD;
            default: return CL_DIV;
        endcase
    endfunction
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int NUM_FU = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [REG_W-1:0]  alloc_fi,
    input  logic [REG_W-1:0]  alloc_fj,
    input  logic [REG_W-1:0]  alloc_fk,
    input  logic [NUM_FU-1:0] alloc_qj,
    input  logic [NUM_FU-1:0] alloc_qk,
    input  logic              exec_done,
    input  logic              wb_go,
    input  logic [NUM_FU-1:0] wb_vec,
    output fu_state_e         state_o,
    output logic [REG_W-1:0]  fi_o,
    output logic [REG_W-1:0]  fj_o,
    output logic [REG_W-1:0]  fk_o,
    output logic              rj_o,
    output logic              rk_o,
    output logic              read_ok,
    output logic              wb_req
);
    fu_state_e         state, state_nx;
    logic [NUM_FU-1:0] qj, qk;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (alloc)         state_nx = ST_WAIT_OPS;
            ST_WAIT_OPS: if (rj_o && rk_o)  state_nx = ST_EXEC;
            ST_EXEC:     if (exec_done)     state_nx = ST_WAIT_WB;
            ST_WAIT_WB:  if (wb_go)         state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        read_ok = (state == ST_WAIT_OPS) && rj_o && rk_o;
        wb_req  = (state == ST_WAIT_WB);
        state_o = state;
    end

    // operand bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fi_o <= '0; fj_o <= '0; fk_o <= '0;
            qj   <= '0; qk   <= '0;
            rj_o <= 1'b0; rk_o <= 1'b0;
        end else if (alloc) begin
            fi_o <= alloc_fi; fj_o <= alloc_fj; fk_o <= alloc_fk;
            qj   <= alloc_qj; qk   <= alloc_qk;
            rj_o <= (alloc_qj == '0);
            rk_o <= (alloc_qk == '0);
        end else if (read_ok) begin
            rj_o <= 1'b0;
            rk_o <= 1'b0;
        end else begin
            if (|(qj & wb_vec)) begin qj <= '0; rj_o <= 1'b1; end
            if (|(qk & wb_vec)) begin qk <= '0; rk_o <= 1'b1; end
        end
    end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
    parameter int NUM_REGS = 32,
    parameter int NUM_FU   = 5,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [REG_W-1:0]  set_idx,
    input  logic [NUM_FU-1:0] set_fu,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  clr_idx,
    input  logic [REG_W-1:0]  look_a,
    input  logic [REG_W-1:0]  look_b,
    input  logic [REG_W-1:0]  look_d,
    output logic [NUM_FU-1:0] prod_a,
    output logic [NUM_FU-1:0] prod_b,
    output logic [NUM_FU-1:0] prod_d
);
    logic [NUM_FU-1:0] tbl [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) tbl[i] <= '0;
        end else begin
            if (clr_en) tbl[clr_idx] <= '0;
            if (set_en) tbl[set_idx] <= set_fu;
        end
    end

    assign prod_a = tbl[look_a];
    assign prod_b = tbl[look_b];
    assign prod_d = tbl[look_d];
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // lowest set bit wins
    assign grant = req & (~req + {{(N-1){1'b0}}, 1'b1});
endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
#(
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG),
    localparam int NFU = NUM_FU
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    input  logic [1:0]     iss_class,
    input  logic [RW-1:0]  iss_dst,
    input  logic [RW-1:0]  iss_src1,
    input  logic [RW-1:0]  iss_src2,
    input  logic [NFU-1:0] exec_done,
    output logic           iss_ready,
    output logic [NFU-1:0] iss_unit,
    output logic [NFU-1:0] rd_grant,
    output logic [NFU-1:0] wb_grant
);
    fu_state_e      st   [NFU];
    logic [RW-1:0]  fi_a [NFU];
    logic [RW-1:0]  fj_a [NFU];
    logic [RW-1:0]  fk_a [NFU];
    logic [NFU-1:0] rj_v, rk_v, read_v, wbreq_v, war_block;
    logic [NFU-1:0] cand, first_free, alloc_v;
    logic [NFU-1:0] prod_s1, prod_s2, prod_d;
    logic [RW-1:0]  wb_dst;

    // candidate units for the offered class
    always_comb begin
        for (int u = 0; u < NFU; u++)
            cand[u] = (st[u] == ST_IDLE) && (unit_class(u) == fu_class_e'(iss_class));
    end

    sb_wb_arb #(.N(NFU)) u_free_pick (.req(cand), .grant(first_free));

    always_comb begin
        iss_unit  = (prod_d != '0) ? '0 : first_free;
        iss_ready = |iss_unit;
        alloc_v   = iss_valid ? iss_unit : '0;
        rd_grant  = read_v;
    end

    for (genvar g = 0; g < NFU; g++) begin : g_fu
        sb_fu_entry #(.REG_W(RW), .NUM_FU(NFU)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc_v[g]),
            .alloc_fi (iss_dst),
            .alloc_fj (iss_src1),
            .alloc_fk (iss_src2),
            .alloc_qj (prod_s1 & ~wb_grant),
            .alloc_qk (prod_s2 & ~wb_grant),
            .exec_done(exec_done[g]),
            .wb_go    (wb_grant[g]),
            .wb_vec   (wb_grant),
            .state_o  (st[g]),
            .fi_o     (fi_a[g]),
            .fj_o     (fj_a[g]),
            .fk_o     (fk_a[g]),
            .rj_o     (rj_v[g]),
            .rk_o     (rk_v[g]),
            .read_ok  (read_v[g]),
            .wb_req   (wbreq_v[g])
        );
    end

    // write-after-read guard: an unread ready source equal to the finisher's destination
    always_comb begin
        for (int w = 0; w < NFU; w++) begin
            war_block[w] = 1'b0;
            for (int u = 0; u < NFU; u++) begin
                if (u != w && st[u] == ST_WAIT_OPS &&
                    ((fj_a[u] == fi_a[w] && rj_v[u]) || (fk_a[u] == fi_a[w] && rk_v[u])))
                    war_block[w] = 1'b1;
            end
        end
    end

    sb_wb_arb #(.N(NFU)) u_wb_pick (.req(wbreq_v & ~war_block), .grant(wb_grant));

    always_comb begin
        wb_dst = '0;
        for (int u = 0; u < NFU; u++)
            if (wb_grant[u]) wb_dst |= fi_a[u];
    end

    sb_reg_status #(.NUM_REGS(NREG), .NUM_FU(NFU)) u_rstat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (|alloc_v),
        .set_idx(iss_dst),
        .set_fu (alloc_v),
        .clr_en (|wb_grant),
        .clr_idx(wb_dst),
        .look_a (iss_src1),
        .look_b (iss_src2),
        .look_d (iss_dst),
        .prod_a (prod_s1),
        .prod_b (prod_s2),
        .prod_d (prod_d)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int N = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         iss_ready,
    input logic [N-1:0] iss_unit,
    input logic [N-1:0] rd_grant,
    input logic [N-1:0] wb_grant
);
    // R6: a single writer per cycle
    p_wb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    // R1, R2: one unit offered, and only when issue is allowed
    p_iss_unit_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_unit));
    p_ready_names_unit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |-> $countones(iss_unit) == 1);

    // R4, R5: a unit never reads and writes back in the same cycle
    p_no_read_and_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & wb_grant) == '0);

    for (genvar u = 0; u < N; u++) begin : g_unit
        // R4: operand read is a single-cycle event per instruction
        p_read_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u] && !wb_grant[u]);
        // R7: after write-back the unit is idle, so no grant follows at once
        p_wb_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant[u] |=> !wb_grant[u] && !rd_grant[u]);
    end
endmodule

bind scoreboard_ctrl sb_checker #(.N(sb_pkg::NUM_FU)) u_sb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iss_ready(iss_ready),
    .iss_unit (iss_unit),
    .rd_grant (rd_grant),
    .wb_grant (wb_grant)
);

// File: tb/scoreboard_ctrl_test.sv
module scoreboard_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_class = 2'd0;
    logic [4:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [4:0] exec_done = '0;
    logic       iss_ready;
    logic [4:0] iss_unit, rd_grant, wb_grant;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    scoreboard_ctrl uut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_class(iss_class),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .exec_done(exec_done), .iss_ready(iss_ready), .iss_unit(iss_unit),
        .rd_grant(rd_grant), .wb_grant(wb_grant)
    );

    // row: valid, class, dst, src1, src2, done | ready, unit, rd, wb
    localparam int NROW = 22;
    localparam logic [38:0] VEC [NROW] = '{
        {1'b1,2'd0,5'd6 ,5'd1 ,5'd1,5'b00000, 1'b1,5'b00001,5'b00000,5'b00000}, // load f6
        {1'b1,2'd1,5'd0 ,5'd2 ,5'd4,5'b00000, 1'b1,5'b00010,5'b00001,5'b00000}, // mul f0
        {1'b1,2'd2,5'd8 ,5'd6 ,5'd0,5'b00001, 1'b1,5'b01000,5'b00010,5'b00000}, // add f8 waits (R3)
        {1'b1,2'd2,5'd10,5'd1 ,5'd1,5'b00000, 1'b0,5'b00000,5'b00000,5'b00001}, // adder busy (R1)
        {1'b1,2'd3,5'd10,5'd0 ,5'd6,5'b00010, 1'b1,5'b10000,5'b00000,5'b00000}, // div f10
        {1'b1,2'd1,5'd8 ,5'd1 ,5'd1,5'b00000, 1'b0,5'b00000,5'b00000,5'b00010}, // WAW stall (R1)
        {1'b0,2'd0,5'd0 ,5'd0 ,5'd0,5'b00000, 1'b1,5'b00001,5'b11000,5'b00000}, // R7 reads after wb
        {1'b1,2'd1,5'd12,5'd14,5'd10,5'b01000,1'b1,5'b00010,5'b00000,5'b00000}, // mul reads f14, waits div
        {1'b1,2'd0,5'd14,5'd1 ,5'd1,5'b00000, 1'b1,5'b00001,5'b00000,5'b01000}, // int writes f14
        {1'b0,2'd2,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b01000,5'b00001,5'b00000},
        {1'b0,2'd2,5'd20,5'd0 ,5'd0,5'b00001, 1'b1,5'b01000,5'b00000,5'b00000},
        {1'b0,2'd2,5'd20,5'd0 ,5'd0,5'b10000, 1'b1,5'b01000,5'b00000,5'b00000}, // R5 int held
        {1'b0,2'd2,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b01000,5'b00000,5'b10000}, // div writes
        {1'b0,2'd2,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b01000,5'b00010,5'b00000}, // R7 mul reads next cycle
        {1'b1,2'd2,5'd16,5'd1 ,5'd1,5'b00000, 1'b1,5'b01000,5'b00000,5'b00001}, // R5 int released
        {1'b1,2'd1,5'd18,5'd1 ,5'd1,5'b00000, 1'b1,5'b00100,5'b01000,5'b00000}, // R2 second multiplier
        {1'b0,2'd0,5'd20,5'd0 ,5'd0,5'b01010, 1'b1,5'b00001,5'b00100,5'b00000},
        {1'b0,2'd0,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b00001,5'b00000,5'b00010}, // R6 lowest first
        {1'b0,2'd0,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b00001,5'b00000,5'b01000}, // R6 then adder
        {1'b0,2'd0,5'd20,5'd0 ,5'd0,5'b00100, 1'b1,5'b00001,5'b00000,5'b00000},
        {1'b0,2'd0,5'd20,5'd0 ,5'd0,5'b00000, 1'b1,5'b00001,5'b00000,5'b00100},
        {1'b0,2'd3,5'd3 ,5'd0 ,5'd0,5'b00000, 1'b1,5'b10000,5'b00000,5'b00000}
    };

    task automatic chk(input string what, input int row, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: actual %b expected %b", what, row, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] d,
                         input logic [4:0] s1, input logic [4:0] s2, input logic [4:0] dn);
        iss_valid = v; iss_class = c; iss_dst = d; iss_src1 = s1; iss_src2 = s2; exec_done = dn;
    endtask

    // sample 2 ns after driving, then move to the next falling edge
    task automatic expect_all(input int row, input logic rdy, input logic [4:0] unit,
                              input logic [4:0] rd, input logic [4:0] wb);
        #2;
        chk("R1 iss_ready", row, {4'b0, iss_ready}, {4'b0, rdy});
        chk("R2 iss_unit",  row, iss_unit, unit);
        chk("R3 rd_grant",  row, rd_grant, rd);
        chk("R5 wb_grant",  row, wb_grant, wb);
        @(negedge clk);
    endtask

    initial begin
        repeat (8000) @(posedge clk);
        if (!done_flag) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: state after reset
        drive(0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
        expect_all(100, 1'b1, 5'b00001, 5'b0, 5'b0);

        for (int i = 0; i < NROW; i++) begin
            logic [38:0] r;
            r = VEC[i];
            drive(r[38], r[37:36], r[35:31], r[30:26], r[25:21], r[20:16]);
            expect_all(i, r[15], r[14:10], r[9:5], r[4:0]);
        end

        // R4: stray done pulses to idle units change nothing
        drive(0, 2'd2, 5'd20, 5'd0, 5'd0, 5'b11111);
        expect_all(200, 1'b1, 5'b01000, 5'b0, 5'b0);
        drive(0, 2'd2, 5'd20, 5'd0, 5'd0, 5'b0);
        expect_all(201, 1'b1, 5'b01000, 5'b0, 5'b0);

        // R1/R7: re-issue to a destination in its write-back cycle waits one cycle
        drive(1, 2'd2, 5'd7, 5'd1, 5'd1, 5'b0);
        expect_all(300, 1'b1, 5'b01000, 5'b0, 5'b0);
        drive(0, 2'd1, 5'd7, 5'd0, 5'd0, 5'b0);
        expect_all(301, 1'b0, 5'b0, 5'b01000, 5'b0);
        drive(0, 2'd1, 5'd7, 5'd0, 5'd0, 5'b01000);
        expect_all(302, 1'b0, 5'b0, 5'b0, 5'b0);
        drive(0, 2'd1, 5'd7, 5'd0, 5'd0, 5'b0);
        expect_all(303, 1'b0, 5'b0, 5'b0, 5'b01000);
        expect_all(304, 1'b1, 5'b00010, 5'b0, 5'b0);

        // R8: reset in flight clears units and the result table
        drive(1, 2'd1, 5'd5, 5'd1, 5'd1, 5'b0);
        expect_all(400, 1'b1, 5'b00010, 5'b0, 5'b0);
        drive(0, 2'd0, 5'd5, 5'd0, 5'd0, 5'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_all(401, 1'b1, 5'b00001, 5'b0, 5'b0);
        drive(0, 2'd1, 5'd9, 5'd0, 5'd0, 5'b0);
        expect_all(402, 1'b1, 5'b00010, 5'b0, 5'b0);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule